// File: doc/BRIEF.md
# ALU Status Flag Unit

This block derives the arithmetic status flags of a 16-bit processor from the operands and result of each ALU operation, and keeps them in a 16-bit flag word together with four control bits. Each ALU operation is described by its class (add, subtract, logic, shift/rotate) and its size (byte or word). A per-flag write mask selects which of the six status flags that operation may change. Carry, auxiliary carry and overflow are worked out from the operand and result bits. The ALU therefore only has to supply the last bit shifted out on shifts.

The control bits are trap, interrupt enable, direction and a mode bit that is stored but has no function. Software can change them through per-bit control loads or a whole-word load, as a pop would do. Taking an interrupt clears interrupt enable and copies the flag word, as it stood before that cycle, into a single-level save slot. An interrupt return copies the save slot back. The flag word reads back with its fixed bits forced. The unit also exports three signals: a trap request after each completed instruction while trap is set, the string pointer direction, and the interrupt enable.

Top module: `psw_flag_unit`

## Requirements
- R1: After reset every stored bit is 0 and `flags_out` reads 16'h7002. Bits 1, 12, 13 and 14 always read 1 and bits 3 and 5 always read 0, whatever was loaded.
- R2: Parity (bit 2) is set to 1 when `alu_res[7:0]` holds an even number of ones, for both byte and word operations.
- R3: Zero (bit 6) is set when the result is zero and sign (bit 7) copies the result's top bit. Byte operations use `alu_res[7:0]` and bit 7; word operations use all 16 bits and bit 15.
- R4: Carry (bit 0) is the carry out of the top bit on add and the borrow into the top bit on subtract. A shift takes `shift_cout` and a logic operation clears it. `alu_op` is encoded as 0 add, 1 subtract, 2 logic, 3 shift.
- R5: Auxiliary carry (bit 4) is the carry from bit 3 into bit 4 on add and the borrow from bit 4 into bit 3 on subtract. It is cleared by logic and shift operations.
- R6: Overflow (bit 11) has a rule for each class. Add: the operands have the same sign and the result sign differs. Subtract: the operand signs differ and the result sign differs from `alu_a`. Shift: the result's top bit differs from `alu_a`'s top bit. Logic: it is cleared.
- R7: When `alu_valid` is 1, each status flag whose `flag_mask` bit is 1 is updated and every other flag keeps its value. The mask bits are 0 carry, 1 parity, 2 aux, 3 zero, 4 sign, 5 overflow. When `alu_valid` is 0, no status flag changes.
- R8: For each `ctl_we` bit that is 1, the control bit takes the matching `ctl_val` bit. The bit order is 0 trap (flag bit 8), 1 interrupt enable (bit 9), 2 direction (bit 10), 3 mode (bit 15).
- R9: `word_we` loads every stored bit from `word_in` in the next cycle. It takes priority over all other updates in that cycle.
- R10: `irq_take` clears interrupt enable, overriding a control load in the same cycle, and saves the pre-cycle flag word. `irq_ret` restores that saved word, unless `word_we` is also high.
- R11: `trap_req` equals `insn_done` AND trap. `str_dec` equals direction. `int_en` equals interrupt enable.
- R12: The mode bit is stored and read back but changes no flag update or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_valid | input | 1 | Apply the status update of this ALU operation |
| alu_op | input | 2 | Operation class: 0 add, 1 subtract, 2 logic, 3 shift |
| alu_word | input | 1 | 1 word operation, 0 byte operation |
| alu_a | input | 16 | First operand |
| alu_b | input | 16 | Second operand |
| alu_res | input | 16 | ALU result |
| shift_cout | input | 1 | Last bit shifted out (shift class) |
| flag_mask | input | 6 | Per-status-flag write enable |
| ctl_we | input | 4 | Per-control-bit load enable |
| ctl_val | input | 4 | Control bit load values |
| word_we | input | 1 | Whole-word load |
| word_in | input | 16 | Whole-word load value |
| irq_take | input | 1 | Interrupt entry |
| irq_ret | input | 1 | Interrupt return |
| insn_done | input | 1 | An instruction completes this cycle |
| flags_out | output | 16 | Flag word with fixed bits forced |
| trap_req | output | 1 | Single-step trap request |
| str_dec | output | 1 | String pointers decrement when 1 |
| int_en | output | 1 | Maskable interrupts enabled |

## Verification
The bench builds the block at its only configuration: a 16-bit word with byte operations on the low 8 bits. At that size every byte operand pair becomes reachable. The add and subtract sweeps run all 256 values of the first operand against 16 values of the second, with the incoming carry alternating, and junk is placed in the upper byte to show it is ignored. Word operations, logic, shifts and all 64 write masks are covered by pseudo-random and full sweeps. Every expected flag comes from integer sums, differences and signed ranges worked out in the bench.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int N_STAT = 6;
    localparam int N_CTRL = 4;

    localparam int POS_CF = 0;
    localparam int POS_PF = 2;
    localparam int POS_AF = 4;
    localparam int POS_ZF = 6;
    localparam int POS_SF = 7;
    localparam int POS_TF = 8;
    localparam int POS_IF = 9;
    localparam int POS_DF = 10;
    localparam int POS_OF = 11;
    localparam int POS_MD = 15;

    localparam logic [WORD_W-1:0] FIXED_ONES = 16'h7002;

    typedef enum logic [1:0] {
        ALU_ADD   = 2'd0,
        ALU_SUB   = 2'd1,
        ALU_LOGIC = 2'd2,
        ALU_SHIFT = 2'd3
    } alu_class_e;

    // bit 0 carry ... bit 5 overflow, matching the write mask order
    typedef struct packed {
        logic ovf;
        logic sign;
        logic zero;
        logic aux;
        logic par;
        logic carry;
    } stat_t;

    typedef struct packed {
        logic mode;
        logic dir;
        logic ie;
        logic trap;
    } ctrl_t;

    typedef struct packed {
        stat_t s;
        ctrl_t c;
    } psw_t;

    function automatic logic even_parity(input logic [BYTE_W-1:0] v);
        return ~(^v);
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input psw_t p);
        logic [WORD_W-1:0] w;
        w = FIXED_ONES;
        w[POS_CF] = p.s.carry;
        w[POS_PF] = p.s.par;
        w[POS_AF] = p.s.aux;
        w[POS_ZF] = p.s.zero;
        w[POS_SF] = p.s.sign;
        w[POS_OF] = p.s.ovf;
        w[POS_TF] = p.c.trap;
        w[POS_IF] = p.c.ie;
        w[POS_DF] = p.c.dir;
        w[POS_MD] = p.c.mode;
        return w;
    endfunction

    function automatic psw_t unpack_word(input logic [WORD_W-1:0] w);
        psw_t p;
        p.s.carry = w[POS_CF];
        p.s.par   = w[POS_PF];
        p.s.aux   = w[POS_AF];
        p.s.zero  = w[POS_ZF];
        p.s.sign  = w[POS_SF];
        p.s.ovf   = w[POS_OF];
        p.c.trap  = w[POS_TF];
        p.c.ie    = w[POS_IF];
        p.c.dir   = w[POS_DF];
        p.c.mode  = w[POS_MD];
        return p;
    endfunction

endpackage

// File: rtl/psw_status_eval.sv
module psw_status_eval
    import psw_pkg::*;
(
    input  alu_class_e        op,
    input  logic              is_word,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic [WORD_W-1:0] r,
    input  logic              shift_cout,
    output stat_t             st
);

    logic a_m, b_m, r_m;
    logic aux_x;

    always_comb begin
        a_m   = is_word ? a[WORD_W-1] : a[BYTE_W-1];
        b_m   = is_word ? b[WORD_W-1] : b[BYTE_W-1];
        r_m   = is_word ? r[WORD_W-1] : r[BYTE_W-1];
        // carry or borrow crossing between the low and high nibble
        aux_x = a[NIB_W] ^ b[NIB_W] ^ r[NIB_W];

        st      = '0;
        st.par  = even_parity(r[BYTE_W-1:0]);
        st.zero = is_word ? (r == '0) : (r[BYTE_W-1:0] == '0);
        st.sign = r_m;

        unique case (op)
            ALU_ADD: begin
                st.carry = (a_m & b_m) | ((a_m ^ b_m) & ~r_m);
                st.aux   = aux_x;
                st.ovf   = (a_m == b_m) && (r_m != a_m);
            end
            ALU_SUB: begin
                st.carry = (~a_m & b_m) | (~(a_m ^ b_m) & r_m);
                st.aux   = aux_x;
                st.ovf   = (a_m != b_m) && (r_m != a_m);
            end
            ALU_SHIFT: begin
                st.carry = shift_cout;
                st.aux   = 1'b0;
                st.ovf   = r_m ^ a_m;
            end
            default: begin
                st.carry = 1'b0;
                st.aux   = 1'b0;
                st.ovf   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/psw_store.sv
module psw_store
    import psw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alu_valid,
    input  logic [N_STAT-1:0] flag_mask,
    input  stat_t             stat_new,
    input  logic [N_CTRL-1:0] ctl_we,
    input  logic [N_CTRL-1:0] ctl_val,
    input  logic              word_we,
    input  logic [WORD_W-1:0] word_in,
    input  logic              irq_take,
    input  logic              irq_ret,
    output psw_t              psw_q
);

    psw_t              shadow_q;
    logic [N_STAT-1:0] stat_cur, stat_in, stat_nxt;
    logic [N_CTRL-1:0] ctrl_cur, ctrl_nxt;
    ctrl_t             ctrl_fin;

    assign stat_cur = psw_q.s;
    assign stat_in  = stat_new;
    assign ctrl_cur = psw_q.c;

    // one select per status flag, gated by its own mask bit
    for (genvar i = 0; i < N_STAT; i++) begin : g_stat
        assign stat_nxt[i] = (alu_valid && flag_mask[i]) ? stat_in[i] : stat_cur[i];
    end

    for (genvar j = 0; j < N_CTRL; j++) begin : g_ctrl
        assign ctrl_nxt[j] = ctl_we[j] ? ctl_val[j] : ctrl_cur[j];
    end

    always_comb begin
        ctrl_fin = ctrl_t'(ctrl_nxt);
        if (irq_take) begin
            ctrl_fin.ie = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            psw_q    <= '0;
            shadow_q <= '0;
        end else if (word_we) begin
            psw_q <= unpack_word(word_in);
        end else if (irq_ret) begin
            psw_q <= shadow_q;
        end else begin
            psw_q.s <= stat_t'(stat_nxt);
            psw_q.c <= ctrl_fin;
            if (irq_take) begin
                shadow_q <= psw_q;
            end
        end
    end

endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
    import psw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        alu_valid,
    input  logic [1:0]  alu_op,
    input  logic        alu_word,
    input  logic [15:0] alu_a,
    input  logic [15:0] alu_b,
    input  logic [15:0] alu_res,
    input  logic        shift_cout,
    input  logic [5:0]  flag_mask,
    input  logic [3:0]  ctl_we,
    input  logic [3:0]  ctl_val,
    input  logic        word_we,
    input  logic [15:0] word_in,
    input  logic        irq_take,
    input  logic        irq_ret,
    input  logic        insn_done,
    output logic [15:0] flags_out,
    output logic        trap_req,
    output logic        str_dec,
    output logic        int_en
);

    stat_t stat_new;
    psw_t  psw_q;

    psw_status_eval u_eval (
        .op         (alu_class_e'(alu_op)),
        .is_word    (alu_word),
        .a          (alu_a),
        .b          (alu_b),
        .r          (alu_res),
        .shift_cout (shift_cout),
        .st         (stat_new)
    );

    psw_store u_store (
        .clk       (clk),
        .rst       (rst),
        .alu_valid (alu_valid),
        .flag_mask (flag_mask),
        .stat_new  (stat_new),
        .ctl_we    (ctl_we),
        .ctl_val   (ctl_val),
        .word_we   (word_we),
        .word_in   (word_in),
        .irq_take  (irq_take),
        .irq_ret   (irq_ret),
        .psw_q     (psw_q)
    );

    assign flags_out = pack_word(psw_q);
    assign trap_req  = insn_done & psw_q.c.trap;
    assign str_dec   = psw_q.c.dir;
    assign int_en    = psw_q.c.ie;

endmodule

// File: rtl/psw_flag_unit_chk.sv
module psw_flag_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        alu_valid,
    input logic [1:0]  alu_op,
    input logic        alu_word,
    input logic [15:0] alu_res,
    input logic [5:0]  flag_mask,
    input logic        word_we,
    input logic [15:0] word_in,
    input logic        irq_take,
    input logic        irq_ret,
    input logic        insn_done,
    input logic [15:0] flags_out,
    input logic        trap_req,
    input logic        str_dec,
    input logic        int_en
);

    AST_TRAP_NEEDS_BIT: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> (flags_out[8] && insn_done)); // R11

    AST_DIR_EXPORT: assert property (@(posedge clk) disable iff (rst)
        str_dec == flags_out[10] && int_en == flags_out[9]); // R11

    AST_FIXED_PATTERN: assert property (@(posedge clk) disable iff (rst)
        word_we |=> (flags_out[14:12] == 3'b111 && flags_out[1] && !flags_out[3] && !flags_out[5])); // R1

    AST_WORD_LOAD: assert property (@(posedge clk) disable iff (rst)
        word_we |=> ((flags_out & 16'h8FD5) == ($past(word_in) & 16'h8FD5))); // R9

    AST_IE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (irq_take && !word_we && !irq_ret) |=> !flags_out[9]); // R10

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!word_we && !irq_ret && !(alu_valid && flag_mask[0])) |=> $stable(flags_out[0])); // R7

    AST_LOGIC_NO_OVF: assert property (@(posedge clk) disable iff (rst)
        (!word_we && !irq_ret && alu_valid && alu_op == 2'd2 && flag_mask[5]) |=> !flags_out[11]); // R6

    AST_ZERO_BY_SIZE: assert property (@(posedge clk) disable iff (rst)
        (!word_we && !irq_ret && alu_valid && flag_mask[3]) |=>
        flags_out[6] == $past((alu_word && alu_res == 16'h0000) || (!alu_word && alu_res[7:0] == 8'h00))); // R3

endmodule

bind psw_flag_unit psw_flag_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .alu_valid (alu_valid),
    .alu_op    (alu_op),
    .alu_word  (alu_word),
    .alu_res   (alu_res),
    .flag_mask (flag_mask),
    .word_we   (word_we),
    .word_in   (word_in),
    .irq_take  (irq_take),
    .irq_ret   (irq_ret),
    .insn_done (insn_done),
    .flags_out (flags_out),
    .trap_req  (trap_req),
    .str_dec   (str_dec),
    .int_en    (int_en)
);

// File: tb/psw_flag_unit_tb.sv
module psw_flag_unit_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        alu_valid;
    logic [1:0]  alu_op;
    logic        alu_word;
    logic [15:0] alu_a, alu_b, alu_res;
    logic        shift_cout;
    logic [5:0]  flag_mask;
    logic [3:0]  ctl_we, ctl_val;
    logic        word_we;
    logic [15:0] word_in;
    logic        irq_take, irq_ret, insn_done;
    logic [15:0] flags_out;
    logic        trap_req, str_dec, int_en;

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;
    logic [15:0] m_reg;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    psw_flag_unit u_dut (
        .clk(clk), .rst(rst), .alu_valid(alu_valid), .alu_op(alu_op),
        .alu_word(alu_word), .alu_a(alu_a), .alu_b(alu_b), .alu_res(alu_res),
        .shift_cout(shift_cout), .flag_mask(flag_mask), .ctl_we(ctl_we),
        .ctl_val(ctl_val), .word_we(word_we), .word_in(word_in),
        .irq_take(irq_take), .irq_ret(irq_ret), .insn_done(insn_done),
        .flags_out(flags_out), .trap_req(trap_req), .str_dec(str_dec),
        .int_en(int_en)
    );

    function automatic logic [15:0] m_read(input logic [15:0] r);
        return (r & 16'h8FD5) | 16'h7002;
    endfunction

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        alu_valid = 0; word_we = 0; irq_take = 0; irq_ret = 0;
        ctl_we = 0; ctl_val = 0; insn_done = 0;
    endtask

    // op: 0 add, 1 sub, 2 logic(xor), 3 shift left by one
    task automatic alu_step(input string tag, input int op, input bit wd,
                            input logic [15:0] a, input logic [15:0] b,
                            input int ci, input logic [5:0] msk, input bit vld);
        int w, half, av, bv, full, sa, sb, sr, rv;
        logic [15:0] res;
        logic [15:0] junk;
        bit c, p, ax, z, s, o, sc;
        int ones;
        w    = wd ? 16 : 8;
        half = 1 << (w - 1);
        av   = wd ? int'(a) : int'(a[7:0]);
        bv   = wd ? int'(b) : int'(b[7:0]);
        sa   = (av >= half) ? av - 2 * half : av;
        sb   = (bv >= half) ? bv - 2 * half : bv;
        step_lfsr();
        junk = lfsr;
        c = 0; ax = 0; o = 0; sc = 0;
        case (op)
            0: begin
                full = av + bv + ci;
                rv   = full % (2 * half);
                c    = (full >= 2 * half);
                ax   = ((av % 16) + (bv % 16) + ci) > 15;
                sr   = sa + sb + ci;
                o    = (sr >= half) || (sr < -half);
            end
            1: begin
                full = av - bv - ci;
                rv   = (full < 0) ? full + 2 * half : full;
                c    = av < bv + ci;
                ax   = (av % 16) < (bv % 16) + ci;
                sr   = sa - sb - ci;
                o    = (sr >= half) || (sr < -half);
            end
            2: begin
                rv = av ^ bv;
            end
            default: begin
                rv = (av * 2) % (2 * half);
                sc = (av >= half);
                c  = sc;
                sr = (rv >= half) ? rv - 2 * half : rv;
                o  = (sr != 2 * sa);
            end
        endcase
        res  = wd ? 16'(rv) : {junk[15:8], 8'(rv)};
        z    = (rv == 0);
        s    = (rv >= half);
        ones = 0;
        for (int k = 0; k < 8; k++) ones += int'(res[k]);
        p    = (ones % 2 == 0);
        if (vld) begin
            if (msk[0]) m_reg[0]  = c;
            if (msk[1]) m_reg[2]  = p;
            if (msk[2]) m_reg[4]  = ax;
            if (msk[3]) m_reg[6]  = z;
            if (msk[4]) m_reg[7]  = s;
            if (msk[5]) m_reg[11] = o;
        end
        @(negedge clk);
        alu_valid  = vld;
        alu_op     = 2'(op);
        alu_word   = wd;
        alu_a      = wd ? a : {junk[7:0], a[7:0]};
        alu_b      = wd ? b : {junk[15:8], b[7:0]};
        alu_res    = res;
        shift_cout = sc;
        flag_mask  = msk;
        @(negedge clk);
        alu_valid = 0;
        chk(tag, flags_out, m_read(m_reg));
    endtask

    task automatic word_load(input logic [15:0] v);
        @(negedge clk);
        word_we = 1; word_in = v;
        @(negedge clk);
        word_we = 0;
        m_reg = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        alu_op = 0; alu_word = 0; alu_a = 0; alu_b = 0; alu_res = 0;
        shift_cout = 0; flag_mask = 0; word_in = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        m_reg = 16'h0000;
        // R1 reset state
        chk("R1 reset word", flags_out, 16'h7002);
        chk("R11 reset outputs", {13'b0, trap_req, str_dec, int_en}, 16'h0);

        // R9 and R1: whole-word loads with the fixed bits forced
        word_load(16'hFFFF);
        chk("R1 R9 load ones", flags_out, 16'hFFD7);
        word_load(16'h0000);
        chk("R1 R9 load zeros", flags_out, 16'h7002);

        // R9: word load wins over an ALU update in the same cycle
        @(negedge clk);
        word_we = 1; word_in = 16'h0800;
        alu_valid = 1; alu_op = 0; alu_word = 0; alu_a = 16'h00FF; alu_b = 16'h0001;
        alu_res = 16'h0000; flag_mask = 6'h3F;
        ctl_we = 4'hF; ctl_val = 4'hF;
        @(negedge clk);
        idle();
        m_reg = 16'h0800;
        chk("R9 priority over alu and ctl", flags_out, m_read(m_reg));

        // R2 R3 R4 R5 R6: byte add and subtract sweeps
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b += 17) begin
                alu_step("R2 R3 R4 R5 R6 byte add", 0, 0, 16'(a), 16'(b), (a + b) % 2, 6'h3F, 1);
                alu_step("R2 R3 R4 R5 R6 byte sub", 1, 0, 16'(a), 16'(b), (a / 3) % 2, 6'h3F, 1);
            end
        // R4 R5 R6: logic and shift byte sweeps
        for (int a = 0; a < 256; a++) begin
            alu_step("R4 R5 R6 byte logic", 2, 0, 16'(a), 16'(255 - a), 0, 6'h3F, 1);
            alu_step("R4 R5 R6 byte shift", 3, 0, 16'(a), 16'h0, 0, 6'h3F, 1);
        end
        // word operations, R3 zero/sign on full word
        for (int i = 0; i < 800; i++) begin
            logic [15:0] x, y;
            step_lfsr(); x = lfsr;
            step_lfsr(); y = (i % 8 == 0) ? x : lfsr;
            alu_step("R2 R3 R4 R5 R6 word add", 0, 1, x, y, i % 2, 6'h3F, 1);
            alu_step("R2 R3 R4 R5 R6 word sub", 1, 1, x, y, (i / 2) % 2, 6'h3F, 1);
            alu_step("R3 R4 R6 word shift", 3, 1, x, 16'h0, 0, 6'h3F, 1);
            alu_step("R3 R4 R6 word logic", 2, 1, x, y, 0, 6'h3F, 1);
        end
        alu_step("R3 word zero", 1, 1, 16'h1234, 16'h1234, 0, 6'h3F, 1);

        // R7: every write mask, and valid low
        for (int i = 0; i < 64; i++)
            for (int j = 0; j < 4; j++) begin
                logic [15:0] x, y;
                step_lfsr(); x = lfsr;
                step_lfsr(); y = lfsr;
                alu_step("R7 mask", j, j[0], x, y, i % 2, 6'(i), 1);
            end
        alu_step("R7 valid low ignored", 0, 0, 16'h00FF, 16'h0001, 0, 6'h3F, 0);

        // R8 R11: control loads one bit at a time
        word_load(16'h0000);
        for (int i = 0; i < 4; i++) begin
            int pos;
            pos = (i == 3) ? 15 : 8 + i;
            @(negedge clk);
            ctl_we = 4'(1 << i); ctl_val = 4'hF;
            @(negedge clk);
            idle();
            m_reg[pos] = 1'b1;
            chk("R8 control load", flags_out, m_read(m_reg));
        end
        @(negedge clk);
        ctl_we = 4'h0; ctl_val = 4'h0;
        @(negedge clk);
        chk("R8 no enable no change", flags_out, m_read(m_reg));
        chk("R11 dir and ie out", {14'b0, str_dec, int_en}, 16'h3);
        insn_done = 1; #1;
        chk("R11 trap request", {15'b0, trap_req}, 16'h1);
        insn_done = 0; #1;
        chk("R11 no trap without done", {15'b0, trap_req}, 16'h0);
        @(negedge clk);
        ctl_we = 4'hF; ctl_val = 4'h0;
        @(negedge clk);
        idle();
        m_reg[8] = 0; m_reg[9] = 0; m_reg[10] = 0; m_reg[15] = 0;
        chk("R8 clear all control", flags_out, m_read(m_reg));
        insn_done = 1; #1;
        chk("R11 trap clear no request", {15'b0, trap_req}, 16'h0);
        insn_done = 0;

        // R10: interrupt entry and return
        word_load(16'h0A55);
        chk("R10 setup", flags_out, 16'h7A57);
        @(negedge clk);
        irq_take = 1; ctl_we = 4'h2; ctl_val = 4'h2;
        @(negedge clk);
        idle();
        chk("R10 ie cleared on entry", flags_out, 16'h7857);
        chk("R10 int_en low", {15'b0, int_en}, 16'h0);
        word_load(16'h0000);
        @(negedge clk);
        irq_ret = 1;
        @(negedge clk);
        idle();
        m_reg = 16'h0A55;
        chk("R10 restored on return", flags_out, 16'h7A57);
        chk("R10 int_en restored", {15'b0, int_en}, 16'h1);
        @(negedge clk);
        irq_ret = 1; word_we = 1; word_in = 16'h0001;
        @(negedge clk);
        idle();
        m_reg = 16'h0001;
        chk("R10 word load beats return", flags_out, m_read(m_reg));

        // R12: mode bit set changes nothing else
        word_load(16'h8000);
        chk("R12 mode readback", flags_out, 16'hF002);
        alu_step("R12 add with mode", 0, 0, 16'h0080, 16'h0080, 0, 6'h3F, 1);
        alu_step("R12 sub with mode", 1, 1, 16'h0000, 16'h0001, 0, 6'h3F, 1);
        insn_done = 1; #1;
        chk("R12 outputs unaffected", {13'b0, trap_req, str_dec, int_en}, 16'h0);
        insn_done = 0;

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule